// File: doc/BRIEF.md
# Four-Instruction Multicycle Execution Core

This block is a small multicycle processor core. It recognises four 32-bit instructions: load upper immediate (LUI), jump-and-link (JAL), word load (LW) and register exclusive-or (XOR). It holds a program counter and a register file of 32 words, each 32 bits wide. The program counter drives a combinational instruction port, and the core executes LUI, JAL and XOR in the same cycle it fetches them.

A word load reads from a byte-wide data port with a one-cycle read latency. It issues four reads to consecutive addresses. The first byte returned lands in the most significant position of the result. The core then spends one writeback cycle, and fetch is stalled for the whole load.

Any other encoding sets a sticky illegal flag and freezes the core until reset. Every register-file write is mirrored one cycle later on a writeback port.

Top module: `xcore_top`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears all 32 registers to 0, and deasserts `illegal`, `wb_en` and `mem_rd_en`.
- R2: An instruction whose destination field (bits 11:7) is 0 writes nothing. `wb_en` stays low, and register 0 reads as 0 afterwards.
- R3: LUI (bits 6:0 = 0110111) writes bits 31:12 of the instruction into the upper 20 bits of rd and clears the low 12 bits.
- R4: XOR (bits 6:0 = 0110011, bits 14:12 = 100, bits 31:25 = 0000000) writes rs1 ^ rs2 into rd, with rs1 in bits 19:15 and rs2 in bits 24:20. Any other value in bits 31:25 makes the instruction illegal.
- R5: JAL (bits 6:0 = 1101111) writes PC+4 into rd and sets the PC to PC plus a sign-extended offset. The offset takes bit 0 as zero, bits 10:1 from instruction bits 30:21, bit 11 from bit 20, bits 19:12 from bits 19:12, and the sign from bit 31. The jump may be backward.
- R6: LW (bits 6:0 = 0000011, bits 14:12 = 010) reads the bytes at base, base+1, base+2 and base+3. The base is rs1 plus the sign-extended bits 31:20, computed modulo 2^32. The result is the four bytes concatenated with the byte from base in bits 31:24.
- R7: During an LW the core asserts `mem_rd_en` for exactly four consecutive cycles and holds the PC. The write of the loaded word is reported on `wb_en` two cycles after the last read cycle.
- R8: LUI, XOR and LW advance the PC by 4 after they retire.
- R9: Any other encoding sets `illegal`. From then until reset the PC does not change, and no register write or memory read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_addr | output | 32 | Program counter, address of the instruction to execute |
| instr_data | input | 32 | Instruction word at `instr_addr`, valid in the same cycle |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte address of the read |
| mem_rdata | input | 8 | Read data, returned one cycle after the request |
| wb_en | output | 1 | A register write took place in the previous cycle |
| wb_rd | output | 5 | Index of that register |
| wb_data | output | 32 | Value written |
| illegal | output | 1 | Sticky unrecognised-instruction flag |

## Verification
The hardest situation to reach is an LW whose base comes from a register filled by an earlier load, where the negative offset makes the address arithmetic borrow across the upper bits. A straight-line program reaches it by loading a large value and then loading again at -4 from it. The program goes on to a forward jump over an illegal word and a backward jump into an XOR. It ends on a zero word, so the halt can be checked against a known PC. Short programs after separate resets then confirm that the registers were cleared, and that an XOR with a wrong funct7 or a load with the wrong width code is rejected.

// File: rtl/xcore_pkg.sv
package xcore_pkg;
  localparam int INSN_W = 32;
  localparam int FLD_W  = 5;

  localparam logic [6:0] OPC_LUI = 7'b0110111;
  localparam logic [6:0] OPC_JAL = 7'b1101111;
  localparam logic [6:0] OPC_LD  = 7'b0000011;
  localparam logic [6:0] OPC_ALU = 7'b0110011;

  typedef enum logic [2:0] {
    K_LUI, K_JAL, K_LW, K_XOR, K_BAD
  } insn_kind_e;

  typedef enum logic [1:0] {
    ST_EXEC, ST_LOAD, ST_WB, ST_HALT
  } core_state_e;
endpackage

// File: rtl/xcore_decode.sv
module xcore_decode
  import xcore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSN_W-1:0] insn,
  output insn_kind_e        kind,
  output logic [FLD_W-1:0]  rd,
  output logic [FLD_W-1:0]  rs1,
  output logic [FLD_W-1:0]  rs2,
  output logic [XLEN-1:0]   imm
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = insn[6:0];
  assign f3  = insn[14:12];
  assign f7  = insn[31:25];
  assign rd  = insn[11:7];
  assign rs1 = insn[19:15];
  assign rs2 = insn[24:20];

  always_comb begin
    kind = K_BAD;
    imm  = '0;
    unique case (opc)
      OPC_LUI: begin
        kind = K_LUI;
        imm  = XLEN'({insn[31:12], 12'h000});
      end
      OPC_JAL: begin
        kind = K_JAL;
        imm  = {{(XLEN-20){insn[31]}}, insn[19:12], insn[20], insn[30:21], 1'b0};
      end
      OPC_LD: begin
        if (f3 == 3'b010) kind = K_LW;
        imm = {{(XLEN-12){insn[31]}}, insn[31:20]};
      end
      OPC_ALU: begin
        if (f3 == 3'b100 && f7 == 7'b0000000) kind = K_XOR;
      end
      default: kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/xcore_regfile.sv
module xcore_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  // R2: the controller never requests a write to the hard-zero entry
  assert_no_zero_write_R2: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr != '0));
endmodule

// File: rtl/xcore_top.sv
module xcore_top
  import xcore_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   instr_addr,
  input  logic [INSN_W-1:0] instr_data,
  output logic              mem_rd_en,
  output logic [XLEN-1:0]   mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              wb_en,
  output logic [FLD_W-1:0]  wb_rd,
  output logic [XLEN-1:0]   wb_data,
  output logic              illegal
);
  localparam int NBYTES = XLEN / 8;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam int ACC_W  = XLEN - 8;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  core_state_e      st_q;
  logic [XLEN-1:0]  pc_q, ld_addr_q, wb_data_q;
  logic [CNT_W-1:0] ld_cnt_q;
  logic [FLD_W-1:0] ld_rd_q, wb_rd_q;
  logic [ACC_W-1:0] acc_q;
  logic             rd_en_q, wb_en_q, ill_q;

  insn_kind_e       kind;
  logic [FLD_W-1:0] rd, rs1, rs2;
  logic [XLEN-1:0]  imm, rs1_val, rs2_val;

  logic             rf_we;
  logic [FLD_W-1:0] rf_waddr;
  logic [XLEN-1:0]  rf_wdata;

  xcore_decode #(.XLEN(XLEN)) u_dec (
    .insn(instr_data), .kind(kind), .rd(rd), .rs1(rs1), .rs2(rs2), .imm(imm)
  );

  xcore_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(rs1), .raddr_b(rs2), .rdata_a(rs1_val), .rdata_b(rs2_val)
  );

  // register write selection: single-cycle ops in EXEC, loads in WB
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = rd;
    rf_wdata = '0;
    case (st_q)
      ST_EXEC: begin
        case (kind)
          K_LUI: begin rf_we = (rd != '0); rf_wdata = imm; end
          K_XOR: begin rf_we = (rd != '0); rf_wdata = rs1_val ^ rs2_val; end
          K_JAL: begin rf_we = (rd != '0); rf_wdata = pc_q + XLEN'(4); end
          default: rf_we = 1'b0;
        endcase
      end
      ST_WB: begin
        rf_we    = (ld_rd_q != '0);
        rf_waddr = ld_rd_q;
        rf_wdata = {acc_q, mem_rdata};
      end
      default: rf_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_EXEC;
      pc_q      <= '0;
      ld_addr_q <= '0;
      ld_cnt_q  <= '0;
      ld_rd_q   <= '0;
      acc_q     <= '0;
      rd_en_q   <= 1'b0;
      wb_en_q   <= 1'b0;
      wb_rd_q   <= '0;
      wb_data_q <= '0;
      ill_q     <= 1'b0;
    end else begin
      wb_en_q   <= rf_we;
      wb_rd_q   <= rf_waddr;
      wb_data_q <= rf_wdata;
      case (st_q)
        ST_EXEC: begin
          case (kind)
            K_LUI, K_XOR: pc_q <= pc_q + XLEN'(4);
            K_JAL:        pc_q <= pc_q + imm;
            K_LW: begin
              ld_addr_q <= rs1_val + imm;
              ld_rd_q   <= rd;
              ld_cnt_q  <= '0;
              rd_en_q   <= 1'b1;
              st_q      <= ST_LOAD;
            end
            default: begin
              ill_q <= 1'b1;
              st_q  <= ST_HALT;
            end
          endcase
        end
        ST_LOAD: begin
          if (ld_cnt_q != '0) acc_q <= {acc_q[ACC_W-9:0], mem_rdata};
          if (ld_cnt_q == LAST) begin
            rd_en_q <= 1'b0;
            st_q    <= ST_WB;
          end else begin
            ld_addr_q <= ld_addr_q + XLEN'(1);
            ld_cnt_q  <= ld_cnt_q + CNT_W'(1);
          end
        end
        ST_WB: begin
          pc_q <= pc_q + XLEN'(4);
          st_q <= ST_EXEC;
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  assign instr_addr = pc_q;
  assign mem_rd_en  = rd_en_q;
  assign mem_addr   = ld_addr_q;
  assign wb_en      = wb_en_q;
  assign wb_rd      = wb_rd_q;
  assign wb_data    = wb_data_q;
  assign illegal    = ill_q;

  // R9: the flag is sticky and the PC is frozen once it is set
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ill_q |=> (ill_q && $stable(pc_q)));

  // R9: a halted core neither writes registers nor reads memory
  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ill_q |-> (!wb_en_q && !rd_en_q));

  // R6: back-to-back byte reads walk consecutive addresses
  assert_load_consecutive_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en_q && $past(rd_en_q)) |-> (ld_addr_q == $past(ld_addr_q) + XLEN'(1)));

  // R7: fetch is stalled while a byte read is outstanding
  assert_fetch_stall_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en_q |=> $stable(pc_q));
endmodule

// File: tb/sim_xcore_top.sv
module sim_xcore_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_addr, instr_data, mem_addr, wb_data;
  logic        mem_rd_en, wb_en, illegal;
  logic [7:0]  mem_rdata = 8'h00;
  logic [4:0]  wb_rd;

  logic [31:0] imem [64];
  int n_chk = 0, n_bad = 0;
  int wb_cnt = 0, rd_cycles = 0, stall_err = 0;
  logic [31:0] addr5 = '0, prev_pc = '0;
  logic        prev_rd = 1'b0;

  always #5 clk = ~clk;

  xcore_top u0 (
    .clk(clk), .rst(rst), .instr_addr(instr_addr), .instr_data(instr_data),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data), .illegal(illegal)
  );

  assign instr_data = imem[instr_addr[7:2]];

  // byte memory: value = low address byte ^ A5, one-cycle latency
  always @(posedge clk) mem_rdata <= mem_addr[7:0] ^ 8'hA5;

  always @(negedge clk) begin
    if (rst) begin
      wb_cnt <= 0; rd_cycles <= 0; stall_err <= 0; prev_rd <= 1'b0;
    end else begin
      if (wb_en) wb_cnt <= wb_cnt + 1;
      if (mem_rd_en) begin
        rd_cycles <= rd_cycles + 1;
        if (rd_cycles == 4) addr5 <= mem_addr;
        if (prev_rd && instr_addr != prev_pc) stall_err <= stall_err + 1;
      end
      prev_rd <= mem_rd_en;
      prev_pc <= instr_addr;
    end
  end

  localparam logic [31:0] PROG [14] = '{
    32'h123450B7, 32'hFF00F137, 32'h0020C1B3, 32'hABCDE037,
    32'h00104233, 32'h04002283, 32'hFFC2A303, 32'h008003EF,
    32'hFFFFFFFF, 32'h0100046F, 32'hFFFFFFFF, 32'h0041C533,
    32'h00000000, 32'hFF9FF4EF };

  // {rd, data} expected on the writeback port, in order
  localparam logic [36:0] EXP [10] = '{
    {5'd1,  32'h12345000}, {5'd2,  32'hFF00F000}, {5'd3,  32'hED34A000},
    {5'd4,  32'h12345000}, {5'd5,  32'hE5E4E7E6}, {5'd6,  32'h47464140},
    {5'd7,  32'h00000020}, {5'd8,  32'h00000028}, {5'd9,  32'h00000038},
    {5'd10, 32'hFF00F000} };
  localparam string TAG [10] = '{"R3", "R3", "R4", "R2", "R6", "R6",
                                 "R5", "R5", "R5", "R4"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_wb(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (wb_en) begin ok = 1'b1; break; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic ok;
    for (int i = 0; i < 64; i++) imem[i] = 32'hFFFFFFFF;
    for (int i = 0; i < 14; i++) imem[i] = PROG[i];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pc", instr_addr, 32'h0);
    chk("R1 illegal", {31'b0, illegal}, 32'h0);
    chk("R1 wb_en", {31'b0, wb_en}, 32'h0);
    chk("R1 mem_rd_en", {31'b0, mem_rd_en}, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < 10; k++) begin
      wait_wb(ok);
      chk({TAG[k], " wb seen"}, {31'b0, ok}, 32'h1);
      chk({TAG[k], " wb rd"}, {27'b0, wb_rd}, {27'b0, EXP[k][36:32]});
      chk({TAG[k], " wb data"}, wb_data, EXP[k][31:0]);
    end
    repeat (10) @(negedge clk);
    chk("R9 illegal set", {31'b0, illegal}, 32'h1);
    chk("R9 pc frozen at 0x30", instr_addr, 32'h30);
    chk("R2 write count (x0 write suppressed)", wb_cnt, 32'd10);
    chk("R7 read cycles for two loads", rd_cycles, 32'd8);
    chk("R6 wrapped base of second load", addr5, 32'hE5E4E7E2);
    chk("R7 pc held during load", stall_err, 32'd0);
    chk("R8 no jump fallthrough", instr_addr, 32'h30);

    // R1: registers cleared by reset; R4: funct7 other than zero is illegal
    do_reset();
    imem[0] = 32'h0041C5B3;
    imem[1] = 32'h4041C5B3;
    rst = 1'b0;
    wait_wb(ok);
    chk("R1 xor of cleared regs seen", {31'b0, ok}, 32'h1);
    chk("R1 cleared regs xor", wb_data, 32'h0);
    repeat (5) @(negedge clk);
    chk("R4 bad funct7 illegal", {31'b0, illegal}, 32'h1);
    chk("R8 pc after one xor", instr_addr, 32'h4);
    chk("R9 no write after halt", wb_cnt, 32'd1);

    // R9: load with wrong width code is illegal and issues no reads
    do_reset();
    imem[0] = 32'h04000283;
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 bad funct3 illegal", {31'b0, illegal}, 32'h1);
    chk("R9 pc held at 0", instr_addr, 32'h0);
    chk("R9 no memory reads", rd_cycles, 32'd0);
    chk("R9 no writes", wb_cnt, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule